// File: doc/BRIEF.md
# Dual Signed Multiply-Subtract Accumulator

This datapath unit takes two packed 32-bit operands, each holding two signed 16-bit halves, and a signed 32-bit accumulate value. It multiplies the low halves together and the high halves together. It subtracts the high-lane product from the low-lane product and adds the accumulate value. The 32-bit result wraps on overflow. An exchange control can first swap the two halves of the second operand, so that the unit forms low-by-high and high-by-low products instead.

The exact sum is kept at 34 signed bits, so only the final accumulate can overflow. When the exact value does not fit in 32 signed bits, the unit raises a per-result overflow bit. It also sets a sticky saturation flag, which holds until a synchronous clear. Every beat passes through a fixed two-stage pipeline, so latency does not depend on the data.

Top module: `dual_mulsub_acc`

## Requirements
- R1: With `in_xchg` = 0, `out_result` equals (A[15:0]·B[15:0]) − (A[31:16]·B[31:16]) + C. All halves and C are treated as two's-complement signed values, and the result is taken modulo 2^32.
- R2: With `in_xchg` = 1, B is rotated right by 16 bits before use, which gives (A[15:0]·B[31:16]) − (A[31:16]·B[15:0]) + C.
- R3: `out_result` is the low 32 bits of the exact result, so a result that does not fit wraps around.
- R4: `out_ovf` is 1 with a valid result exactly when the exact result lies outside [−2^31, 2^31−1].
- R5: `sat_flag` becomes 1 in the same cycle that an overflowing valid result appears. It stays at 1 until it is cleared.
- R6: A `clr_sat` pulse sampled on an edge makes `sat_flag` 0 after that edge. If an overflowing result is loaded on the same edge, the flag ends at 1.
- R7: `out_valid` equals `in_valid` delayed by exactly two clock edges for any data values. Back-to-back beats and beats separated by gaps are both supported.
- R8: While `rst` is sampled high, `out_valid` and `sat_flag` are forced to 0. After reset the pipeline holds no valid beats.
- R9: The products and their difference never overflow on their own. For example, both operands equal to 0x80008000 with C = 0 give a result of 0 and `out_ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat qualifier |
| in_a | input | 32 | First packed operand, two signed halves |
| in_b | input | 32 | Second packed operand, two signed halves |
| in_c | input | 32 | Signed accumulate value |
| in_xchg | input | 1 | 1 swaps the halves of `in_b` before use |
| clr_sat | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result qualifier, two cycles after `in_valid` |
| out_result | output | 32 | Wrapped 32-bit result |
| out_ovf | output | 1 | Overflow of this result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The assertions check the following on every cycle:
- the two-cycle valid delay;
- that the sticky flag only rises with an overflowing valid result;
- that the flag never falls without a clear;
- that a clear without a concurrent overflow leaves it low.

The arithmetic cannot be checked by an assertion without copying the datapath. The wrapped values, the exchange ordering, the overflow boundaries at both ends of the 32-bit range and the clear-versus-set collision are shown only by the bench's directed and random scenarios, which are compared with a 64-bit model.

// File: rtl/dmsa_pkg.sv
package dmsa_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int PROD_W = 2 * HALF_W;
    localparam int SUM_W  = WORD_W + 2;
    localparam int LANES  = 2;

    typedef logic [HALF_W-1:0]        half_t;
    typedef logic [WORD_W-1:0]        word_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [SUM_W-1:0]  sum_t;

    // contents of the product register stage
    typedef struct packed {
        logic  valid;
        prod_t p_lo;
        prod_t p_hi;
        word_t acc;
    } prod_stage_t;

    // contents of the result register stage
    typedef struct packed {
        logic  valid;
        word_t result;
        logic  ovf;
    } res_stage_t;

    function automatic half_t half_of(input word_t w, input int idx);
        return w[idx*HALF_W +: HALF_W];
    endfunction

    function automatic word_t swap_halves(input word_t w);
        return {w[HALF_W-1:0], w[WORD_W-1:HALF_W]};
    endfunction

    // true when the exact sum lies outside the signed word range
    function automatic logic exceeds_word(input sum_t s);
        logic [SUM_W-WORD_W:0] top;
        top = s[SUM_W-1:WORD_W-1];
        return !((&top) || !(|top));
    endfunction

endpackage

// File: rtl/dmsa_operand_sel.sv
module dmsa_operand_sel
    import dmsa_pkg::*;
(
    input  word_t b_in,
    input  logic  xchg,
    output word_t b_eff
);
    always_comb begin
        b_eff = xchg ? swap_halves(b_in) : b_in;
    end
endmodule

// File: rtl/dmsa_prod_stage.sv
module dmsa_prod_stage
    import dmsa_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid,
    input  word_t       a,
    input  word_t       b,
    input  word_t       c,
    output prod_stage_t q
);
    prod_t lane_prod [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        half_t ha;
        half_t hb;
        always_comb begin
            ha = half_of(a, g);
            hb = half_of(b, g);
            lane_prod[g] = prod_t'($signed(ha)) * prod_t'($signed(hb));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.valid <= 1'b0;
        end else begin
            q.valid <= valid;
        end
        q.p_lo <= lane_prod[0];
        q.p_hi <= lane_prod[1];
        q.acc  <= c;
    end
endmodule

// File: rtl/dmsa_acc_stage.sv
module dmsa_acc_stage
    import dmsa_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  prod_stage_t d,
    output logic        ovf_set,
    output res_stage_t  q
);
    sum_t exact;
    logic ovf_now;

    always_comb begin
        exact   = sum_t'($signed(d.p_lo)) - sum_t'($signed(d.p_hi))
                + sum_t'($signed(d.acc));
        ovf_now = exceeds_word(exact);
        ovf_set = d.valid && ovf_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.valid <= 1'b0;
        end else begin
            q.valid <= d.valid;
        end
        q.result <= exact[WORD_W-1:0];
        q.ovf    <= ovf_now;
    end
endmodule

// File: rtl/dmsa_sticky.sv
module dmsa_sticky (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            flag <= (flag && !clr) || set;
        end
    end
endmodule

// File: rtl/dual_mulsub_acc.sv
module dual_mulsub_acc
    import dmsa_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_a,
    input  logic [31:0] in_b,
    input  logic [31:0] in_c,
    input  logic        in_xchg,
    input  logic        clr_sat,
    output logic        out_valid,
    output logic [31:0] out_result,
    output logic        out_ovf,
    output logic        sat_flag
);
    word_t       b_eff;
    prod_stage_t s1;
    res_stage_t  s2;
    logic        ovf_set;

    dmsa_operand_sel u_sel (
        .b_in  (in_b),
        .xchg  (in_xchg),
        .b_eff (b_eff)
    );

    dmsa_prod_stage u_prod (
        .clk   (clk),
        .rst   (rst),
        .valid (in_valid),
        .a     (in_a),
        .b     (b_eff),
        .c     (in_c),
        .q     (s1)
    );

    dmsa_acc_stage u_acc (
        .clk     (clk),
        .rst     (rst),
        .d       (s1),
        .ovf_set (ovf_set),
        .q       (s2)
    );

    dmsa_sticky u_sticky (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_sat),
        .set  (ovf_set),
        .flag (sat_flag)
    );

    assign out_valid  = s2.valid;
    assign out_result = s2.result;
    assign out_ovf    = s2.valid && s2.ovf;
endmodule

// File: rtl/dual_mulsub_acc_chk.sv
module dual_mulsub_acc_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic clr_sat,
    input logic out_valid,
    input logic out_ovf,
    input logic sat_flag
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    // R7: valid travels through exactly two stages
    p_valid_delay_r7: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R8: nothing valid leaves the pipe right after reset
    p_empty_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd0) |-> (!out_valid && !sat_flag));

    // R5: flag rises only together with an overflowing valid result
    p_flag_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && $rose(sat_flag)) |-> (out_valid && out_ovf));

    // R5: an overflowing result is always reflected in the flag
    p_ovf_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ovf) |-> sat_flag);

    // R6: flag falls only after a clear
    p_fall_needs_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && $fell(sat_flag)) |-> $past(clr_sat));

    // R6: a clear with no concurrent overflow leaves the flag low
    p_clear_works_r6: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && $past(clr_sat) && !(out_valid && out_ovf)) |-> !sat_flag);

endmodule

bind dual_mulsub_acc dual_mulsub_acc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .clr_sat   (clr_sat),
    .out_valid (out_valid),
    .out_ovf   (out_ovf),
    .sat_flag  (sat_flag)
);

// File: tb/dual_mulsub_acc_bench.sv
module dual_mulsub_acc_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_a, in_b, in_c;
    logic        in_xchg;
    logic        clr_sat;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_ovf;
    logic        sat_flag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dual_mulsub_acc u_dual_mulsub_acc (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_a       (in_a),
        .in_b       (in_b),
        .in_c       (in_c),
        .in_xchg    (in_xchg),
        .clr_sat    (clr_sat),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_ovf    (out_ovf),
        .sat_flag   (sat_flag)
    );

    typedef struct {
        logic        v;
        logic [31:0] r;
        logic        o;
    } exp_t;

    exp_t        st1, st2, pend;
    logic        sticky_m;
    logic        clr_d, rst_d;
    string       tag_d1, tag_d2;

    function automatic exp_t model(logic v, logic [31:0] a, logic [31:0] b,
                                   logic [31:0] c, logic x);
        exp_t e;
        logic [31:0] bb;
        longint p1, p2, s;
        bb = x ? {b[15:0], b[31:16]} : b;
        p1 = longint'($signed(a[15:0])) * longint'($signed(bb[15:0]));
        p2 = longint'($signed(a[31:16])) * longint'($signed(bb[31:16]));
        s  = p1 - p2 + longint'($signed(c));
        e.v = v;
        e.r = s[31:0];
        e.o = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        return e;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one cycle: update model for the edge just passed, compare, drive next
    task automatic step(string tag, logic v, logic [31:0] a, logic [31:0] b,
                        logic [31:0] c, logic x, logic clr, logic r);
        @(posedge clk);
        #1;
        if (rst_d) begin
            st1 = '{1'b0, 32'h0, 1'b0};
            st2 = '{1'b0, 32'h0, 1'b0};
            sticky_m = 1'b0;
        end else begin
            sticky_m = (sticky_m && !clr_d) || (st1.v && st1.o);
            st2 = st1;
            st1 = pend;
        end
        tag_d2 = tag_d1;
        tag_d1 = tag;
        check(rst_d ? "R8" : tag_d2, "out_valid", {31'd0, out_valid}, {31'd0, st2.v});
        if (st2.v) begin
            check(tag_d2, "out_result", out_result, st2.r);
            check(tag_d2, "out_ovf", {31'd0, out_ovf}, {31'd0, st2.o});
        end
        check(rst_d ? "R8" : "R5", "sat_flag", {31'd0, sat_flag}, {31'd0, sticky_m});
        @(negedge clk);
        in_valid = v; in_a = a; in_b = b; in_c = c; in_xchg = x;
        clr_sat = clr; rst = r;
        pend  = model(v, a, b, c, x);
        clr_d = clr;
        rst_d = r;
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b1; in_a = '1; in_b = '1; in_c = '1;
        in_xchg = 1'b0; clr_sat = 1'b0;
        rst_d = 1'b1; clr_d = 1'b0;
        pend = '{1'b0, 32'h0, 1'b0};
        st1 = pend; st2 = pend; sticky_m = 1'b0;
        tag_d1 = "R8"; tag_d2 = "R8";
        @(negedge clk);
        // R8: reset held with valid input present
        for (int i = 0; i < 3; i++) step("R8", 1'b1, 32'h7fff7fff, 32'h80008000, 32'h7fffffff, 1'b0, 1'b0, 1'b1);
        idle("R8", 2);

        // R1 / R2: exchange ordering
        step("R1", 1'b1, 32'h00030002, 32'h00050007, 32'h00000000, 1'b0, 1'b0, 1'b0);
        step("R2", 1'b1, 32'h00030002, 32'h00050007, 32'h00000000, 1'b1, 1'b0, 1'b0);
        step("R2", 1'b1, 32'hfffd0009, 32'h0004fff9, 32'h00001000, 1'b1, 1'b0, 1'b0);
        // R9: extreme halves without and with exchange
        step("R9", 1'b1, 32'h80008000, 32'h80008000, 32'h00000000, 1'b0, 1'b0, 1'b0);
        step("R9", 1'b1, 32'h80008000, 32'h80008000, 32'h00000000, 1'b1, 1'b0, 1'b0);
        idle("R7", 3);

        // R3 / R4 / R5: max accumulate plus positive difference
        step("R4", 1'b1, 32'h00008000, 32'h00008000, 32'h7fffffff, 1'b0, 1'b0, 1'b0);
        idle("R5", 3);
        // R6: plain clear
        step("R6", 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0);
        idle("R6", 2);
        // R3: min accumulate minus positive difference
        step("R3", 1'b1, 32'h80000000, 32'h80000000, 32'h80000000, 1'b0, 1'b0, 1'b0);
        // R6: clear arrives on the same edge as the overflow load
        step("R6", 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0);
        idle("R6", 3);
        step("R6", 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0);
        // R4: exact boundary, fits
        step("R4", 1'b1, 32'h00000001, 32'h00000001, 32'h7ffffffe, 1'b0, 1'b0, 1'b0);
        step("R4", 1'b1, 32'h00010000, 32'h00010000, 32'h80000001, 1'b0, 1'b0, 1'b0);
        step("R4", 1'b1, 32'h00010000, 32'h00010000, 32'h80000000, 1'b0, 1'b0, 1'b0);
        idle("R7", 3);

        // R7 / R1: random traffic with gaps, exchange and clears
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] ra, rb, rc;
            ra = $urandom(); rb = $urandom(); rc = $urandom();
            if (($urandom() % 8) == 0) ra = {16'h8000, ra[15:0]};
            if (($urandom() % 8) == 0) rb = {rb[31:16], 16'h8000};
            if (($urandom() % 6) == 0) rc = ($urandom() % 2) ? 32'h7fffffff : 32'h80000000;
            step("R7", ($urandom() % 4) != 0, ra, rb, rc, $urandom() % 2,
                 ($urandom() % 16) == 0, 1'b0);
        end
        // R8: reset in mid-stream
        step("R8", 1'b1, 32'h00008000, 32'h00008000, 32'h7fffffff, 1'b0, 1'b0, 1'b0);
        step("R8", 1'b1, 32'h00008000, 32'h00008000, 32'h7fffffff, 1'b0, 1'b0, 1'b1);
        idle("R8", 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule